// File: doc/BRIEF.md
# Dual-Bank Level Interrupt Controller

This block gathers forty level-sensitive interrupt lines and steers each one to one of two processor request outputs: a fast request and a normal request. The lines are split over two banks. Sources 0 to 31 occupy bank 0 at their own bit position, and sources 32 to 39 occupy the low eight bits of bank 1. Every source has an enable bit and a steering bit. A source takes part in a request only while its line is high and its enable bit is set.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge and reads are combinational. The port gives filtered and unfiltered pending views, the enable and steering registers, a wake policy bit, and forty priority slot words. The slot words are stored for a separate priority resolver. A third output asks an idle core to wake, and the policy bit decides whether disabled sources may still cause that wake.

Top module: `dbic_top`

## Requirements
- R1: Source n with n < 32 appears at bit n of bank 0. Source n with n >= 32 appears at bit n-32 of bank 1. The bank 0 raw pending word is at offset 0x10 and the bank 1 raw pending word is at offset 0xAC.
- R2: A raw pending bit equals the present level of its input line, read in the same cycle. It holds no memory of an earlier high level.
- R3: Within bank 0, offset 0x0C reads pending & enable & steer, and offset 0x00 reads pending & enable & ~steer. Bank 1 has the same two views at 0xA8 and 0x9C.
- R4: `fast_irq` is high when some source is pending, enabled and steered fast (steer bit 1). `norm_irq` is high when some source is pending, enabled and steered normal (steer bit 0). Both outputs are registered and follow a change one clock edge later.
- R5: The enable registers are at 0x04 (bank 0) and 0xA0 (bank 1). The steering registers are at 0x08 and 0xA4. All four read back what was written, except that bank 1 bits 31:8 always read zero.
- R6: The wake policy register at 0x14 stores bit 0 of a write. It reads back that bit with all other bits zero.
- R7: `wake` is combinational. It is high only while `idle_i` is high and a source is pending. With policy bit 1 the pending source must also be enabled. With policy bit 0 any pending source counts.
- R8: Priority slot i is at 0x1C+4i for i < 32 and at 0xB0+4(i-32) for i >= 32. A write stores only bits 31 and 5:0 (mask 0x8000003F), and other slots are left unchanged.
- R9: Writes to the pending views, the raw pending words, the highest-priority word (0x18) and unmapped offsets change no state. The highest-priority word and unmapped offsets read zero.
- R10: After reset the enable, steering, policy and slot registers are zero, and `fast_irq` and `norm_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Interrupt line levels |
| idle_i | input | 1 | Core is idle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| fast_irq | output | 1 | Registered fast request |
| norm_irq | output | 1 | Registered normal request |
| wake | output | 1 | Wake request to an idle core |

## Verification
The bench uses the default parameters: NUM_SRC = 40 and BANK_W = 32. With these values bank 1 is only partly populated, with eight live bits out of thirty-two. That makes the masking of absent bits in the bank 1 enable register observable, and it puts the second, separate window of priority slots (slots 32 to 39) within reach of the tests. These defaults also place the last slot at 0xCC, the top of the map, so the boundary between slot decode and unmapped offsets can be checked at 0xD0.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
   localparam int unsigned OFS_NPEND = 32'h00;
   localparam int unsigned OFS_MASK  = 32'h04;
   localparam int unsigned OFS_ROUTE = 32'h08;
   localparam int unsigned OFS_FPEND = 32'h0C;
   localparam int unsigned OFS_RAW   = 32'h10;
   localparam int unsigned OFS_CTL   = 32'h14;
   localparam int unsigned OFS_HP    = 32'h18;
   localparam int unsigned SLOT_LO   = 32'h1C;
   localparam int unsigned BANK1_BASE = 32'h9C;
   localparam int unsigned SLOT_HI   = 32'hB0;
   localparam int unsigned SLOTS_LO_N = 32;
   localparam logic [31:0] PRIO_KEEP = 32'h8000_003F;

   function automatic int unsigned bank_base(input int unsigned k);
      return (k == 0) ? 32'h0 : BANK1_BASE;
   endfunction

   function automatic int unsigned slot_addr(input int unsigned i);
      return (i < SLOTS_LO_N) ? SLOT_LO + 4 * i : SLOT_HI + 4 * (i - SLOTS_LO_N);
   endfunction
endpackage

// File: rtl/dbic_bank.sv
module dbic_bank #(
   parameter int BANK_W  = 32,
   parameter int VALID_W = 32,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] pend_i,
   input  logic              we_mask,
   input  logic              we_route,
   input  logic [DATA_W-1:0] wdata,
   output logic [BANK_W-1:0] mask_o,
   output logic [BANK_W-1:0] route_o,
   output logic [BANK_W-1:0] fast_o,
   output logic [BANK_W-1:0] norm_o
);
   logic [BANK_W-1:0] keep;
   logic [BANK_W-1:0] wd;

   generate
      if (VALID_W >= BANK_W) begin : g_full
         assign keep = '1;
      end else begin : g_part
         assign keep = {{(BANK_W-VALID_W){1'b0}}, {VALID_W{1'b1}}};
      end
   endgenerate

   assign wd = BANK_W'(wdata) & keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o  <= '0;
         route_o <= '0;
      end else begin
         if (we_mask)  mask_o  <= wd;
         if (we_route) route_o <= wd;
      end
   end

   assign fast_o = pend_i & keep & mask_o & route_o;
   assign norm_o = pend_i & keep & mask_o & ~route_o;
endmodule

// File: rtl/dbic_prio.sv
module dbic_prio #(
   parameter int          NUM_SLOT = 40,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] KEEP     = 32'h8000_003F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SLOT-1:0] we_slot,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   slot_o [NUM_SLOT]
);
   localparam logic [DATA_W-1:0] KEEP_W = DATA_W'(KEEP);

   generate
      for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          slot_o[i] <= '0;
            else if (we_slot[i]) slot_o[i] <= wdata & KEEP_W;
         end
      end
   endgenerate
endmodule

// File: rtl/dbic_outs.sv
module dbic_outs (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_any,
   input  logic norm_any,
   input  logic wake_any,
   input  logic idle_i,
   output logic fast_irq,
   output logic norm_irq,
   output logic wake
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_irq <= 1'b0;
         norm_irq <= 1'b0;
      end else begin
         fast_irq <= fast_any;
         norm_irq <= norm_any;
      end
   end

   assign wake = idle_i & wake_any;
endmodule

// File: rtl/dbic_top.sv
module dbic_top
   import dbic_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int BANK_W  = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               idle_i,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               fast_irq,
   output logic               norm_irq,
   output logic               wake
);
   localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
   localparam int PAD_W     = NUM_BANKS * BANK_W;

   generate
      if (BANK_W != 32 || DATA_W != 32) begin : g_bad_width
         $error("dbic_top: register map needs 32-bit banks and data");
      end
      if (NUM_BANKS != 2 || NUM_SRC > 40) begin : g_bad_count
         $error("dbic_top: map holds 33 to 40 sources in two banks");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("dbic_top: offsets need at least 8 address bits");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [PAD_W-1:0]     src_pad;
   logic [BANK_W-1:0]    raw_b   [NUM_BANKS];
   logic [BANK_W-1:0]    mask_b  [NUM_BANKS];
   logic [BANK_W-1:0]    route_b [NUM_BANKS];
   logic [BANK_W-1:0]    fview_b [NUM_BANKS];
   logic [BANK_W-1:0]    nview_b [NUM_BANKS];
   logic [NUM_BANKS-1:0] we_mask, we_route;
   logic [NUM_SRC-1:0]   we_slot;
   logic [DATA_W-1:0]    slot_q  [NUM_SRC];
   logic                 ctl_q;
   logic                 fast_any, norm_any, wake_any;

   assign src_pad = PAD_W'(src_lvl);

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
         localparam int LEFT  = NUM_SRC - k * BANK_W;
         localparam int VALID = (LEFT < BANK_W) ? LEFT : BANK_W;
         assign raw_b[k]    = src_pad[k*BANK_W +: BANK_W];
         assign we_mask[k]  = bus_we && hit(bus_addr, bank_base(k) + OFS_MASK);
         assign we_route[k] = bus_we && hit(bus_addr, bank_base(k) + OFS_ROUTE);
         dbic_bank #(.BANK_W(BANK_W), .VALID_W(VALID), .DATA_W(DATA_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .pend_i(raw_b[k]),
            .we_mask(we_mask[k]), .we_route(we_route[k]), .wdata(bus_wdata),
            .mask_o(mask_b[k]), .route_o(route_b[k]),
            .fast_o(fview_b[k]), .norm_o(nview_b[k]));
      end
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot_we
         assign we_slot[i] = bus_we && hit(bus_addr, slot_addr(i));
      end
   endgenerate

   dbic_prio #(.NUM_SLOT(NUM_SRC), .DATA_W(DATA_W), .KEEP(PRIO_KEEP)) u_prio (
      .clk(clk), .rst_n(rst_n), .we_slot(we_slot), .wdata(bus_wdata), .slot_o(slot_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctl_q <= 1'b0;
      else if (bus_we && hit(bus_addr, OFS_CTL)) ctl_q <= bus_wdata[0];
   end

   always_comb begin
      fast_any = 1'b0;
      norm_any = 1'b0;
      wake_any = 1'b0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         fast_any = fast_any | (|fview_b[k]);
         norm_any = norm_any | (|nview_b[k]);
         wake_any = wake_any | (ctl_q ? |(raw_b[k] & mask_b[k]) : |raw_b[k]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFS_CTL)) bus_rdata = DATA_W'(ctl_q);
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (hit(bus_addr, bank_base(k) + OFS_NPEND)) bus_rdata = DATA_W'(nview_b[k]);
         if (hit(bus_addr, bank_base(k) + OFS_MASK))  bus_rdata = DATA_W'(mask_b[k]);
         if (hit(bus_addr, bank_base(k) + OFS_ROUTE)) bus_rdata = DATA_W'(route_b[k]);
         if (hit(bus_addr, bank_base(k) + OFS_FPEND)) bus_rdata = DATA_W'(fview_b[k]);
         if (hit(bus_addr, bank_base(k) + OFS_RAW))   bus_rdata = DATA_W'(raw_b[k]);
      end
      for (int i = 0; i < NUM_SRC; i++) begin
         if (hit(bus_addr, slot_addr(i))) bus_rdata = slot_q[i];
      end
   end

   dbic_outs u_outs (
      .clk(clk), .rst_n(rst_n), .fast_any(fast_any), .norm_any(norm_any),
      .wake_any(wake_any), .idle_i(idle_i),
      .fast_irq(fast_irq), .norm_irq(norm_irq), .wake(wake));
endmodule

// File: rtl/dbic_sva.sv
module dbic_sva #(
   parameter int NUM_SRC = 40,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_lvl,
   input logic               idle_i,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               fast_irq,
   input logic               norm_irq,
   input logic               wake,
   input logic               ctl_q,
   input logic               fast_any,
   input logic               norm_any
);
   p_fast_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> fast_irq == $past(fast_any));
   p_norm_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> norm_irq == $past(norm_any));
   p_wake_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> idle_i);
   p_wake_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && !ctl_q && (|src_lvl)) |-> wake);
   p_raw_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h10)) |-> bus_rdata == DATA_W'(src_lvl[31:0]));
   p_ctl_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h14)) |-> bus_rdata == DATA_W'(ctl_q));
   p_slot_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h1C)) |-> (bus_rdata & DATA_W'(32'h7FFF_FFC0)) == '0);
   p_hp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h18)) |-> bus_rdata == '0);
endmodule

bind dbic_top dbic_sva #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .idle_i(idle_i),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .fast_irq(fast_irq),
   .norm_irq(norm_irq), .wake(wake), .ctl_q(ctl_q),
   .fast_any(fast_any), .norm_any(norm_any));

// File: tb/tb_dbic_top.sv
`timescale 1ns/1ps
module tb_dbic_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] src_lvl = '0;
   logic        idle_i = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fast_irq, norm_irq, wake;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   dbic_top dut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .idle_i(idle_i),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .fast_irq(fast_irq), .norm_irq(norm_irq), .wake(wake));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h04, v); chk("R10 mask b0", v, 0);
      rd(8'hA0, v); chk("R10 mask b1", v, 0);
      rd(8'h08, v); chk("R10 steer b0", v, 0);
      rd(8'h14, v); chk("R10 policy", v, 0);
      rd(8'hCC, v); chk("R10 slot39", v, 0);
      chk("R10 fast_irq", {31'b0, fast_irq}, 0);
      chk("R10 norm_irq", {31'b0, norm_irq}, 0);
   endtask

   task automatic t_mapping();
      logic [31:0] v;
      src_lvl = (40'd1 << 5) | (40'd1 << 35);
      rd(8'h10, v); chk("R1 raw b0", v, 32'h20);
      rd(8'hAC, v); chk("R1 raw b1", v, 32'h08);
      tick();
      src_lvl = '0;
      rd(8'h10, v); chk("R2 raw b0 cleared", v, 0);
      rd(8'hAC, v); chk("R2 raw b1 cleared", v, 0);
   endtask

   task automatic t_route();
      logic [31:0] v;
      wr(8'h04, 32'h0000_00FF);
      wr(8'h08, 32'h0000_000F);
      src_lvl = 40'h0000_0444;
      rd(8'h00, v); chk("R3 normal view b0", v, 32'h40);
      rd(8'h0C, v); chk("R3 fast view b0", v, 32'h04);
      chk("R4 fast before edge", {31'b0, fast_irq}, 0);
      tick();
      chk("R4 fast after edge", {31'b0, fast_irq}, 1);
      chk("R4 norm after edge", {31'b0, norm_irq}, 1);
      src_lvl = 40'h0000_0004;
      chk("R4 norm held", {31'b0, norm_irq}, 1);
      tick();
      chk("R4 norm dropped", {31'b0, norm_irq}, 0);
      chk("R4 fast kept", {31'b0, fast_irq}, 1);
      src_lvl = '0;
      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, v); chk("R5 mask b1 absent bits", v, 32'hFF);
      wr(8'hA4, 32'h0000_0001);
      rd(8'hA4, v); chk("R5 steer b1", v, 32'h01);
      rd(8'h08, v); chk("R5 steer b0", v, 32'h0F);
      src_lvl = (40'd1 << 32) | (40'd1 << 33);
      rd(8'hA8, v); chk("R3 fast view b1", v, 32'h01);
      rd(8'h9C, v); chk("R3 normal view b1", v, 32'h02);
      tick();
      chk("R4 fast from b1", {31'b0, fast_irq}, 1);
      chk("R4 norm from b1", {31'b0, norm_irq}, 1);
      src_lvl = '0;
      wr(8'h04, 32'h0);
      wr(8'hA0, 32'h0);
      tick();
      chk("R4 fast idle", {31'b0, fast_irq}, 0);
   endtask

   task automatic t_wake();
      logic [31:0] v;
      idle_i = 1'b1;
      src_lvl = 40'd1 << 7;
      #1; chk("R7 wake any source", {31'b0, wake}, 1);
      wr(8'h14, 32'h0000_0001);
      #1; chk("R7 wake blocked by policy", {31'b0, wake}, 0);
      rd(8'h14, v); chk("R6 policy set", v, 1);
      wr(8'h14, 32'hFFFF_FFFE);
      rd(8'h14, v); chk("R6 policy clear", v, 0);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, v); chk("R6 policy only bit0", v, 1);
      wr(8'h04, 32'h0000_0080);
      #1; chk("R7 wake enabled source", {31'b0, wake}, 1);
      idle_i = 1'b0;
      #1; chk("R7 no wake when busy", {31'b0, wake}, 0);
      src_lvl = '0;
      wr(8'h04, 32'h0);
      wr(8'h14, 32'h0);
   endtask

   task automatic t_prio();
      logic [31:0] v;
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h98, 32'h1234_5678);
      wr(8'hB0, 32'h8000_0001);
      wr(8'hCC, 32'hFFFF_FFFF);
      rd(8'h1C, v); chk("R8 slot0", v, 32'h8000_003F);
      rd(8'h98, v); chk("R8 slot31", v, 32'h0000_0038);
      rd(8'hB0, v); chk("R8 slot32", v, 32'h8000_0001);
      rd(8'hCC, v); chk("R8 slot39", v, 32'h8000_003F);
      rd(8'h20, v); chk("R8 slot1 untouched", v, 0);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr(8'h04, 32'h0000_0010);
      src_lvl = 40'd1 << 4;
      wr(8'h10, 32'h0);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'hD0, 32'hFFFF_FFFF);
      rd(8'h10, v); chk("R9 raw after write", v, 32'h10);
      rd(8'h00, v); chk("R9 normal view after write", v, 32'h10);
      rd(8'h0C, v); chk("R9 fast view after write", v, 0);
      rd(8'h04, v); chk("R9 mask unchanged", v, 32'h10);
      rd(8'h08, v); chk("R9 steer unchanged", v, 32'h0F);
      rd(8'h18, v); chk("R9 hp word zero", v, 0);
      rd(8'hD0, v); chk("R9 unmapped zero", v, 0);
      rd(8'hFC, v); chk("R9 unmapped top", v, 0);
      src_lvl = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mapping();
      t_route();
      t_wake();
      t_prio();
      t_ignored();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule